// File: doc/BRIEF.md
# 4x4 Inverse Residual Transform Engine

This block turns one 4x4 block of signed 16-bit transform coefficients into a 4x4 block of signed 16-bit spatial residuals. It offers three ways of doing this, chosen per block. The first is a separable 4-point inverse cosine-style transform. The second is a separable 4-point inverse sine-style kernel, used for small intra luma blocks. The third is a DC-only shortcut that fills the whole block with one value derived from the top-left coefficient. The two separable kernels run a vertical pass and then a horizontal pass. After each pass the block is rounded, shifted right and clamped to 16 bits. Between the passes the block is transposed.

A block enters as one packed 256-bit word through a valid/ready handshake, together with a 2-bit mode. The block leaves the same way. The engine holds one block at a time. Each pass takes one clock, because four identical lanes transform all four columns at once. The lanes write their results back transposed, so the same lanes serve both passes. A controlling state machine steps through these states: IDLE (waiting for a block), COL (first pass), ROW (second pass), DCFILL (shortcut fill) and DONE (result offered). Its transitions are: IDLE to COL on accept in a transform mode, IDLE to DCFILL on accept in DC mode, COL to ROW, ROW to DONE, DCFILL to DONE, and DONE to IDLE when the result is taken.

Top module: `itx4_engine`

## Requirements
- R1: `in_ready` is high only in IDLE. A block and its mode are captured on a clock edge where `in_valid` and `in_ready` are both high. Any change to `in_valid`, `in_blk` or `in_mode` while the engine is busy has no effect on the result in progress.
- R2: `out_valid` rises exactly two clock edges after the accept edge in the transform modes, and exactly one edge after it in DC mode.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_blk` does not change. After the edge where both are high, `out_valid` is low and `in_ready` is high.
- R4: In cosine mode, an input vector s0..s3 gives e0=64(s0+s2), e1=64(s0-s2), o0=83s1+36s3 and o1=36s1-83s3. The outputs, in index order 0..3, are e0+o0, e1+o1, e1-o1 and e0-o0.
- R5: In sine mode, with c0=s0+s2, c1=s2+s3, c2=s0-s3 and c3=74s1, the outputs in index order 0..3 are 29c0+55c1+c3, 55c2-29c1+c3, 74(s0-s2+s3) and 55c0+29c2-c3.
- R6: Kernel sums are formed at 32 bits. After the first pass each sum has 64 added and is arithmetically shifted right by 7. After the second pass each sum has 2048 added and is shifted right by 12. Each result is clamped to the range -32768..32767.
- R7: Coefficient (r,c) sits at bits [(r*4+c)*16 +: 16] of both the input and output words. The first pass transforms each column. The second pass transforms each row of that intermediate result. The output is laid out row-major.
- R8: In DC mode every output element equals ((d+1)>>>1 + 32)>>>6, where d is the signed coefficient at (0,0). All other input coefficients are ignored.
- R9: Mode encoding is 0 = cosine, 1 = sine, 2 = DC-only. Code 3 behaves exactly like code 0.
- R10: During and right after reset, `in_ready` is 1, `out_valid` is 0 and `out_blk` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Engine can accept a block |
| in_mode | input | 2 | Transform selection, captured at accept |
| in_blk | input | 256 | Sixteen signed 16-bit coefficients, row-major |
| out_valid | output | 1 | Result block offered |
| out_ready | input | 1 | Consumer takes the result |
| out_blk | output | 256 | Sixteen signed 16-bit residuals, row-major |

## Verification
A wrong state in the controller shows up at the handshake pins. If the controller skips a pass or repeats one, `out_valid` rises one edge early or late, and the latency count measured from the accept edge catches this at once. If a pass uses the wrong rounding constant, the wrong shift, or the wrong kernel, or if a lane reads the buffer without transposing it, the fault changes specific output elements. This is visible when the result is first offered, and is compared against a model computed in the bench. Mode capture and the hold of the result are checked over the cycles that follow: the bench changes the inputs while the engine is busy and stalls the consumer.

// File: rtl/itx4_pkg.sv
package itx4_pkg;

    localparam int PTS       = 4;
    localparam int SHIFT_COL = 7;
    localparam int SHIFT_ROW = 12;

    typedef enum logic [1:0] {
        MODE_DCT = 2'd0,
        MODE_DST = 2'd1,
        MODE_DC  = 2'd2,
        MODE_ALT = 2'd3
    } xform_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COL,
        S_ROW,
        S_DCFILL,
        S_DONE
    } itx_state_e;

endpackage

// File: rtl/itx4_kernel.sv
module itx4_kernel
    import itx4_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32
) (
    input  logic [PTS*IN_W-1:0]  vec_i,
    input  logic                 dst_i,
    output logic [PTS*ACC_W-1:0] acc_o
);

    localparam logic signed [ACC_W-1:0] K29 = ACC_W'(29);
    localparam logic signed [ACC_W-1:0] K36 = ACC_W'(36);
    localparam logic signed [ACC_W-1:0] K55 = ACC_W'(55);
    localparam logic signed [ACC_W-1:0] K64 = ACC_W'(64);
    localparam logic signed [ACC_W-1:0] K74 = ACC_W'(74);
    localparam logic signed [ACC_W-1:0] K83 = ACC_W'(83);

    logic signed [ACC_W-1:0] a [PTS];

    for (genvar k = 0; k < PTS; k++) begin : g_ext
        assign a[k] = ACC_W'($signed(vec_i[k*IN_W +: IN_W]));
    end

    // cosine butterfly terms
    logic signed [ACC_W-1:0] ev0, ev1, od0, od1;
    // sine kernel terms
    logic signed [ACC_W-1:0] c0, c1, c2, c3;
    logic signed [ACC_W-1:0] y [PTS];

    always_comb begin
        ev0 = K64 * (a[0] + a[2]);
        ev1 = K64 * (a[0] - a[2]);
        od0 = K83 * a[1] + K36 * a[3];
        od1 = K36 * a[1] - K83 * a[3];

        c0 = a[0] + a[2];
        c1 = a[2] + a[3];
        c2 = a[0] - a[3];
        c3 = K74 * a[1];

        if (dst_i) begin
            y[0] = K29 * c0 + K55 * c1 + c3;
            y[1] = K55 * c2 - K29 * c1 + c3;
            y[2] = K74 * (a[0] - a[2] + a[3]);
            y[3] = K55 * c0 + K29 * c2 - c3;
        end else begin
            y[0] = ev0 + od0;
            y[1] = ev1 + od1;
            y[2] = ev1 - od1;
            y[3] = ev0 - od0;
        end
    end

    for (genvar k = 0; k < PTS; k++) begin : g_pack
        assign acc_o[k*ACC_W +: ACC_W] = y[k];
    end

endmodule

// File: rtl/itx4_rsat.sv
module itx4_rsat #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 16,
    parameter int SH_LO = 7,
    parameter int SH_HI = 12
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic                    row_pass_i,
    output logic        [OUT_W-1:0] val_o
);

    localparam logic signed [ACC_W-1:0] RND_LO = ACC_W'(2 ** (SH_LO - 1));
    localparam logic signed [ACC_W-1:0] RND_HI = ACC_W'(2 ** (SH_HI - 1));
    localparam logic signed [ACC_W-1:0] MAXV   = ACC_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] MINV   = ~MAXV;

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        biased  = acc_i + (row_pass_i ? RND_HI : RND_LO);
        shifted = row_pass_i ? (biased >>> SH_HI) : (biased >>> SH_LO);
        if (shifted > MAXV) begin
            val_o = OUT_W'(MAXV);
        end else if (shifted < MINV) begin
            val_o = OUT_W'(MINV);
        end else begin
            val_o = OUT_W'(shifted);
        end
    end

endmodule

// File: rtl/itx4_lane.sv
module itx4_lane
    import itx4_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32
) (
    input  logic [PTS*IN_W-1:0] vec_i,
    input  logic                dst_i,
    input  logic                row_pass_i,
    output logic [PTS*IN_W-1:0] vec_o
);

    logic [PTS*ACC_W-1:0] sums;

    itx4_kernel #(
        .IN_W  (IN_W),
        .ACC_W (ACC_W)
    ) kern_i (
        .vec_i (vec_i),
        .dst_i (dst_i),
        .acc_o (sums)
    );

    for (genvar k = 0; k < PTS; k++) begin : g_rs
        itx4_rsat #(
            .ACC_W (ACC_W),
            .OUT_W (IN_W),
            .SH_LO (SHIFT_COL),
            .SH_HI (SHIFT_ROW)
        ) rs_i (
            .acc_i      ($signed(sums[k*ACC_W +: ACC_W])),
            .row_pass_i (row_pass_i),
            .val_o      (vec_o[k*IN_W +: IN_W])
        );
    end

endmodule

// File: rtl/itx4_engine.sv
module itx4_engine
    import itx4_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [1:0]                    in_mode,
    input  logic [PTS*PTS*COEF_W-1:0]     in_blk,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [PTS*PTS*COEF_W-1:0]     out_blk
);

    localparam int VEC_W = PTS * COEF_W;
    localparam int DCX_W = COEF_W + 2;

    itx_state_e  state_q, state_d;
    xform_mode_e mode_q;
    logic [COEF_W-1:0] grid_q [PTS][PTS];

    logic accept;
    assign accept = in_valid && in_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = (xform_mode_e'(in_mode) == MODE_DC) ? S_DCFILL : S_COL;
                end
            end
            S_COL:    state_d = S_ROW;
            S_ROW:    state_d = S_DONE;
            S_DCFILL: state_d = S_DONE;
            S_DONE: begin
                if (out_ready) begin
                    state_d = S_IDLE;
                end
            end
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------- handshake outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            S_IDLE:   in_ready  = 1'b1;
            S_DONE:   out_valid = 1'b1;
            S_COL, S_ROW, S_DCFILL: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    // ---------------- transform lanes ----------------
    logic [VEC_W-1:0] col_vec  [PTS];
    logic [VEC_W-1:0] lane_out [PTS];
    logic             use_dst;
    logic             row_pass;

    assign use_dst  = (mode_q == MODE_DST);
    assign row_pass = (state_q == S_ROW);

    always_comb begin
        for (int c = 0; c < PTS; c++) begin
            for (int k = 0; k < PTS; k++) begin
                col_vec[c][k*COEF_W +: COEF_W] = grid_q[k][c];
            end
        end
    end

    for (genvar c = 0; c < PTS; c++) begin : g_lane
        itx4_lane #(
            .IN_W  (COEF_W),
            .ACC_W (ACC_W)
        ) lane_i (
            .vec_i      (col_vec[c]),
            .dst_i      (use_dst),
            .row_pass_i (row_pass),
            .vec_o      (lane_out[c])
        );
    end

    // ---------------- DC shortcut value ----------------
    logic signed [DCX_W-1:0] dc_ext, dc_half, dc_bias, dc_res;
    logic        [COEF_W-1:0] dc_val;

    always_comb begin
        dc_ext  = DCX_W'($signed(grid_q[0][0])) + DCX_W'(1);
        dc_half = dc_ext >>> 1;
        dc_bias = dc_half + DCX_W'(32);
        dc_res  = dc_bias >>> 6;
        dc_val  = COEF_W'(dc_res);
    end

    // ---------------- block buffer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_DCT;
            for (int r = 0; r < PTS; r++) begin
                for (int c = 0; c < PTS; c++) begin
                    grid_q[r][c] <= '0;
                end
            end
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        mode_q <= xform_mode_e'(in_mode);
                        for (int r = 0; r < PTS; r++) begin
                            for (int c = 0; c < PTS; c++) begin
                                grid_q[r][c] <= in_blk[(r*PTS+c)*COEF_W +: COEF_W];
                            end
                        end
                    end
                end
                S_COL, S_ROW: begin
                    // lane c transformed column c; its result becomes row c
                    for (int c = 0; c < PTS; c++) begin
                        for (int j = 0; j < PTS; j++) begin
                            grid_q[c][j] <= lane_out[c][j*COEF_W +: COEF_W];
                        end
                    end
                end
                S_DCFILL: begin
                    for (int r = 0; r < PTS; r++) begin
                        for (int c = 0; c < PTS; c++) begin
                            grid_q[r][c] <= dc_val;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        for (int r = 0; r < PTS; r++) begin
            for (int c = 0; c < PTS; c++) begin
                out_blk[(r*PTS+c)*COEF_W +: COEF_W] = grid_q[r][c];
            end
        end
    end

    // ---------------- assertions ----------------
    logic dc_uniform;
    always_comb begin
        dc_uniform = 1'b1;
        for (int i = 1; i < PTS*PTS; i++) begin
            if (out_blk[i*COEF_W +: COEF_W] != out_blk[COEF_W-1:0]) begin
                dc_uniform = 1'b0;
            end
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    tx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode != 2'd2) |-> ##3 out_valid);

    // R2
    dc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'd2) |-> ##2 out_valid);

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_blk)));

    // R3
    out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R8
    dc_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == MODE_DC) |-> dc_uniform);

endmodule

// File: tb/itx4_engine_tb_top.sv
`timescale 1ns/1ps
module itx4_engine_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [1:0]   in_mode;
    logic [255:0] in_blk;
    logic         out_valid;
    logic         out_ready;
    logic [255:0] out_blk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    itx4_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_mode   (in_mode),
        .in_blk    (in_blk),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_blk   (out_blk)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic longint kern(input int m, input int j,
                                    input longint s0, input longint s1,
                                    input longint s2, input longint s3);
        longint e0, e1, o0, o1, c0, c1, c2, c3;
        if (m == 1) begin
            c0 = s0 + s2; c1 = s2 + s3; c2 = s0 - s3; c3 = 74 * s1;
            case (j)
                0: return 29 * c0 + 55 * c1 + c3;
                1: return 55 * c2 - 29 * c1 + c3;
                2: return 74 * (s0 - s2 + s3);
                default: return 55 * c0 + 29 * c2 - c3;
            endcase
        end
        e0 = 64 * (s0 + s2); e1 = 64 * (s0 - s2);
        o0 = 83 * s1 + 36 * s3; o1 = 36 * s1 - 83 * s3;
        case (j)
            0: return e0 + o0;
            1: return e1 + o1;
            2: return e1 - o1;
            default: return e0 - o0;
        endcase
    endfunction

    function automatic int rsat(input longint a, input int sh);
        longint v;
        v = (a + (longint'(1) <<< (sh - 1))) >>> sh;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    function automatic int elem(input logic [255:0] b, input int r, input int c);
        return int'($signed(b[(r*4+c)*16 +: 16]));
    endfunction

    function automatic logic [255:0] ref_blk(input int m, input logic [255:0] x);
        logic [255:0] res;
        int z [4][4];
        int d, v;
        res = '0;
        if (m == 2) begin
            d = elem(x, 0, 0);
            v = (((d + 1) >>> 1) + 32) >>> 6;
            for (int i = 0; i < 16; i++) res[i*16 +: 16] = 16'(v);
            return res;
        end
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 4; k++)
                z[k][c] = rsat(kern(m, k, elem(x,0,c), elem(x,1,c), elem(x,2,c), elem(x,3,c)), 7);
        for (int r = 0; r < 4; r++)
            for (int j = 0; j < 4; j++)
                res[(r*4+j)*16 +: 16] = 16'(rsat(kern(m, j, z[r][0], z[r][1], z[r][2], z[r][3]), 12));
        return res;
    endfunction

    function automatic logic [255:0] mk(input int seed, input int amp);
        logic [255:0] b;
        bit [31:0] u;
        int v;
        u = 32'(seed);
        for (int i = 0; i < 16; i++) begin
            u = u * 32'd1103515245 + 32'd12345;
            v = int'(u[30:8] % 23'(2 * amp + 1)) - amp;
            b[i*16 +: 16] = 16'(v);
        end
        return b;
    endfunction

    function automatic logic [255:0] fill(input int v);
        logic [255:0] b;
        for (int i = 0; i < 16; i++) b[i*16 +: 16] = 16'(v);
        return b;
    endfunction

    // ---------------- check helper ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- one block through the engine ----------------
    task automatic run_blk(input logic [1:0] m, input logic [255:0] blk,
                           input bit junk, input string req,
                           output logic [255:0] got);
        logic [255:0] held;
        int lat, exp_lat;
        exp_lat = (m == 2'd2) ? 1 : 2;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "ready before accept", 256'(in_ready), 256'(1));
        in_valid = 1'b1; in_blk = blk; in_mode = m;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1", "ready drops after accept", 256'(in_ready), 256'(0));
        if (junk) begin
            in_blk  = ~blk;
            in_mode = (m == 2'd2) ? 2'd1 : 2'd2;
        end else begin
            in_valid = 1'b0;
        end
        lat = 0;
        while (!out_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R2", "latency", 256'(lat), 256'(exp_lat));
        got = out_blk;
        chk(got == ref_blk(int'(m), blk), req, "result block", got, ref_blk(int'(m), blk));
        held = out_blk;
        repeat (2) @(negedge clk);
        chk(out_valid && out_blk == held, "R3", "hold while stalled", out_blk, held);
        out_ready = 1'b1;
        in_valid  = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R3", "release after take",
            256'({out_valid, in_ready}), 256'(2'b01));
        out_ready = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'd0; in_blk = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid && out_blk == '0, "R10", "reset state",
            out_blk, 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid && out_blk == '0, "R10", "after reset",
            256'({in_ready, out_valid}), 256'(2'b10));
    endtask

    task automatic t_impulse();
        logic [255:0] b, got;
        b = '0; b[15:0] = 16'sd64;
        run_blk(2'd0, b, 1'b0, "R4", got);
        chk(got == fill(1), "R4", "cosine impulse gives all ones", got, fill(1));
        run_blk(2'd1, b, 1'b0, "R5", got);
        chk(got[15:0] == 16'd0 && got[255:240] == 16'd1, "R5",
            "sine impulse corners", got, ref_blk(1, b));
    endtask

    task automatic t_dc();
        logic [255:0] b, got;
        b = mk(7, 3000); b[15:0] = 16'sd64;
        run_blk(2'd2, b, 1'b0, "R8", got);
        chk(got == fill(1), "R8", "dc 64 with other coefficients ignored", got, fill(1));
        b[15:0] = -16'sd200;
        run_blk(2'd2, b, 1'b0, "R8", got);
        chk(got == fill(-2), "R8", "dc -200", got, fill(-2));
        b[15:0] = -16'sd1;
        run_blk(2'd2, b, 1'b0, "R8", got);
        chk(got == fill(0), "R8", "dc -1", got, fill(0));
        b[15:0] = 16'sd32767;
        run_blk(2'd2, b, 1'b0, "R8", got);
        chk(got == fill(256), "R8", "dc max", got, fill(256));
    endtask

    task automatic t_patterns();
        logic [255:0] got;
        for (int i = 0; i < 4; i++) begin
            run_blk(2'd0, mk(100 + i, 200 << (3 * i)), 1'b0, "R4 R7", got);
            run_blk(2'd1, mk(300 + i, 200 << (3 * i)), 1'b0, "R5 R7", got);
        end
    endtask

    task automatic t_saturate();
        logic [255:0] got;
        run_blk(2'd0, fill(32767),  1'b0, "R6", got);
        run_blk(2'd0, fill(-32768), 1'b0, "R6", got);
        run_blk(2'd1, fill(32767),  1'b0, "R6", got);
        run_blk(2'd1, fill(-32768), 1'b0, "R6", got);
        run_blk(2'd0, mk(55, 32767), 1'b0, "R6", got);
    endtask

    task automatic t_mode3();
        logic [255:0] b, got;
        b = mk(900, 5000);
        run_blk(2'd3, b, 1'b0, "R9", got);
        chk(got == ref_blk(0, b), "R9", "code 3 equals cosine", got, ref_blk(0, b));
    endtask

    task automatic t_busy_ignore();
        logic [255:0] got;
        run_blk(2'd0, mk(41, 9000), 1'b1, "R1", got);
        run_blk(2'd1, mk(42, 9000), 1'b1, "R1", got);
        run_blk(2'd2, mk(43, 9000), 1'b1, "R1", got);
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_dc();
        t_patterns();
        t_saturate();
        t_mode3();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule